// File: doc/BRIEF.md
# Token-Chain Weighted Round-Robin Queue Selector

This block decides which queue an output port serves next. There are thirty-two guaranteed-rate queues and one best-effort queue. Per-queue status comes in as two vectors: one says the queue holds no cells, the other says its credit for the current frame is used up. A flag reports whether the best-effort queue holds cells. A one-cycle `start` pulse launches a decision. The index of the queue that sent last is captured with it. The surrounding scheduler keeps the status vectors steady until `done`.

A token walks a chain of per-queue control elements. It starts at the queue just after the previous sender, and it covers four elements per clock. A small register carries the token state from one group to the next, so one full lap of the chain costs eight cycles.

- **First lap:** a queue must hold a cell and have credit left to catch the token. The previous sender is checked last.
- **After the first lap:** if nobody caught the token, the best-effort queue is chosen when it has cells.
- **Second lap:** if the best-effort queue is also empty, a second lap runs that ignores credit. It keeps the link busy whenever any cell is waiting.

Top module: `wrr_token_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `active` is all zero and `abr_sel`, `idle` and `done` are 0.
- R2: Count token offsets k = 1..32 from the queue after the registered last sender, wrapping modulo 32. In the first lap, the first offset whose queue has `q_empty`=0 and `q_zero`=0 is selected. `done` rises ceil(k/4) clock edges after the edge that samples `start`, and bit q of `active` is set, where q is that queue's index.
- R3: The previous sender is offset 32 of the first lap. If it alone has a cell and credit, it is selected at edge 8, even when the best-effort queue holds cells.
- R4: If no queue is selected in the first lap and `abr_avail`=1, `abr_sel` is set and `done` rises at edge 8, with `active` all zero.
- R5: If the first lap fails and `abr_avail`=0, a second lap over the same offsets selects the first queue with `q_empty`=0, whatever its `q_zero`. `done` then rises at edge 8+ceil(k/4).
- R6: If every queue is empty and `abr_avail`=0, `idle` is set with `active` all zero, and `done` rises at edge 16.
- R7: `active` never has more than one bit set. At most one of {`active` nonzero, `abr_sel`, `idle`} holds at any time.
- R8: Every accepted `start` produces exactly one single-cycle `done`, no later than 16 edges after it. Before `done`, the result outputs read zero.
- R9: A `start` pulse that arrives while a decision is in progress is ignored, and the running decision's result and timing are unchanged.
- R10: `last_idx` is sampled only at an accepted `start`. Later changes have no effect on the decision in progress.
- R11: After `done`, `active`, `abr_sel` and `idle` hold their values until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a decision (ignored while busy) |
| last_idx | input | 5 | Queue that transmitted in the previous cell cycle |
| q_empty | input | 32 | Per-queue flag: 1 = no cells held |
| q_zero | input | 32 | Per-queue flag: 1 = credit exhausted this frame |
| abr_avail | input | 1 | Best-effort queue holds at least one cell |
| active | output | 32 | One-hot selected guaranteed-rate queue |
| abr_sel | output | 1 | Best-effort queue selected |
| idle | output | 1 | Nothing to send |
| done | output | 1 | One-cycle pulse: result valid from this cycle |

## Verification
The checker watches the following on every cycle:
- `active` stays one-hot or zero.
- The three kinds of result never overlap.
- `done` lasts one cycle and always carries a result.
- The outputs stay frozen while the block is idle.
- No decision runs past sixteen cycles.

Which queue wins, and on which exact edge, depends on the token order from the last sender, the credit flags, the best-effort fallback and the second lap. Only the bench's reference model can show these, by comparing every cycle of each scenario. The scenarios include wrap-around and the previous sender winning last. They also pulse `start` and change `last_idx` during a decision.

// File: rtl/wrr_tc_pkg.sv
package wrr_tc_pkg;
   // which lap of the token chain is running
   typedef enum logic {
      LAP_CREDIT = 1'b0,   // queue needs a cell and credit
      LAP_ANY    = 1'b1    // queue needs a cell only
   } lap_t;
endpackage

// File: rtl/wrr_tc_rotate.sv
// Reorders a per-queue vector into token order: bit k is the queue at offset k+1 from base.
module wrr_tc_rotate #(
   parameter int NQ = 32,
   localparam int IW = $clog2(NQ)
) (
   input  logic [IW-1:0] base,
   input  logic [NQ-1:0] vec,
   output logic [NQ-1:0] rot
);
   for (genvar k = 0; k < NQ; k++) begin : g_lane
      assign rot[k] = vec[base + IW'(k + 1)];
   end
endmodule

// File: rtl/wrr_tc_chain.sv
// One group of control elements: the token enters at lane 0 and stops at the first eligible lane.
module wrr_tc_chain #(
   parameter int GRP = 4,
   localparam int LW = $clog2(GRP)
) (
   input  logic [GRP-1:0] elig,
   output logic [LW-1:0]  lane,
   output logic           pass
);
   logic [GRP:0]   carry;
   logic [GRP-1:0] take;

   assign carry[0] = 1'b1;
   for (genvar i = 0; i < GRP; i++) begin : g_elem
      assign take[i]    = carry[i] & elig[i];
      assign carry[i+1] = carry[i] & ~elig[i];
   end
   assign pass = carry[GRP];

   always_comb begin
      lane = '0;
      for (int i = 0; i < GRP; i++)
         if (take[i]) lane = LW'(i);
   end
endmodule

// File: rtl/wrr_token_sel.sv
module wrr_token_sel #(
   parameter int NQ  = 32,
   parameter int GRP = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [$clog2(NQ)-1:0] last_idx,
   input  logic [NQ-1:0]         q_empty,
   input  logic [NQ-1:0]         q_zero,
   input  logic                  abr_avail,
   output logic [NQ-1:0]         active,
   output logic                  abr_sel,
   output logic                  idle,
   output logic                  done
);
   import wrr_tc_pkg::*;

   localparam int IW = $clog2(NQ);
   localparam int NG = NQ / GRP;
   localparam int GW = $clog2(NG);
   localparam int LW = $clog2(GRP);

   // elaboration-time parameter checks
   if (GRP < 2 || (1 << LW) != GRP) begin : g_bad_grp
      $error("GRP must be a power of two and at least 2");
   end
   if (NQ < 2 * GRP || (1 << IW) != NQ) begin : g_bad_nq
      $error("NQ must be a power of two and at least two groups");
   end

   logic          busy;
   lap_t          lap;
   logic [GW-1:0] grp_q;
   logic [IW-1:0] last_q;

   logic [NQ-1:0]  elig, tok_elig;
   logic [GRP-1:0] grp_elig;
   logic [LW-1:0]  lane;
   logic           pass;
   logic [IW-1:0]  win_idx;

   assign elig = (lap == LAP_CREDIT) ? (~q_empty & ~q_zero) : ~q_empty;

   wrr_tc_rotate #(.NQ(NQ)) u_rot (
      .base (last_q),
      .vec  (elig),
      .rot  (tok_elig)
   );

   assign grp_elig = tok_elig[grp_q*GRP +: GRP];

   wrr_tc_chain #(.GRP(GRP)) u_chain (
      .elig (grp_elig),
      .lane (lane),
      .pass (pass)
   );

   assign win_idx = last_q + IW'(1) + {grp_q, lane};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         lap     <= LAP_CREDIT;
         grp_q   <= '0;
         last_q  <= '0;
         active  <= '0;
         abr_sel <= 1'b0;
         idle    <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy    <= 1'b1;
               lap     <= LAP_CREDIT;
               grp_q   <= '0;
               last_q  <= last_idx;
               active  <= '0;
               abr_sel <= 1'b0;
               idle    <= 1'b0;
            end
         end else if (!pass) begin
            active <= NQ'(1) << win_idx;
            done   <= 1'b1;
            busy   <= 1'b0;
         end else if (grp_q == GW'(NG - 1)) begin
            if (lap == LAP_CREDIT) begin
               if (abr_avail) begin
                  abr_sel <= 1'b1;
                  done    <= 1'b1;
                  busy    <= 1'b0;
               end else begin
                  lap   <= LAP_ANY;
                  grp_q <= '0;
               end
            end else begin
               idle <= 1'b1;
               done <= 1'b1;
               busy <= 1'b0;
            end
         end else begin
            grp_q <= grp_q + GW'(1);
         end
      end
   end
endmodule

// File: rtl/wrr_token_sel_chk.sv
module wrr_token_sel_chk #(
   parameter int NQ  = 32,
   parameter int GRP = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic [NQ-1:0] active,
   input logic          abr_sel,
   input logic          idle,
   input logic          done
);
   localparam int LIM = 2 * (NQ / GRP);
   localparam int CW  = $clog2(LIM) + 2;

   logic [CW-1:0] run_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)     run_cnt <= '0;
      else if (busy)  run_cnt <= run_cnt + CW'(1);
      else            run_cnt <= '0;
   end

   // R7
   active_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(active));
   // R7
   result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({|active, abr_sel, idle}) <= 1);
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   done_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (|active || abr_sel || idle));
   // R8
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= CW'(LIM));
   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(active) && $stable(abr_sel) && $stable(idle)));
endmodule

bind wrr_token_sel wrr_token_sel_chk #(.NQ(NQ), .GRP(GRP)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .active  (active),
   .abr_sel (abr_sel),
   .idle    (idle),
   .done    (done)
);

// File: tb/sim_wrr_token_sel.sv
module sim_wrr_token_sel;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [4:0]  last_idx;
   logic [31:0] q_empty, q_zero;
   logic        abr_avail;
   logic [31:0] active;
   logic        abr_sel, idle, done;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   wrr_token_sel u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .last_idx(last_idx),
      .q_empty(q_empty), .q_zero(q_zero), .abr_avail(abr_avail),
      .active(active), .abr_sel(abr_sel), .idle(idle), .done(done)
   );

   // reference: expected result and the edge count at which done rises
   task automatic predict(input logic [31:0] emp, input logic [31:0] zer, input logic abr,
                          input int last, output logic [31:0] e_act, output logic e_abr,
                          output logic e_idle, output int lat);
      e_act = '0; e_abr = 0; e_idle = 0; lat = 0;
      for (int k = 1; k <= 32 && lat == 0; k++) begin
         int q = (last + k) % 32;
         if (!emp[q] && !zer[q]) begin e_act[q] = 1'b1; lat = (k - 1) / 4 + 1; end
      end
      if (lat == 0 && abr) begin e_abr = 1; lat = 8; end
      for (int k = 1; k <= 32 && lat == 0; k++) begin
         int q = (last + k) % 32;
         if (!emp[q]) begin e_act[q] = 1'b1; lat = 8 + (k - 1) / 4 + 1; end
      end
      if (lat == 0) begin e_idle = 1; lat = 16; end
   endtask

   task automatic check(input string tag, input int n, input logic [31:0] ea,
                        input logic eb, input logic ei, input logic ed);
      n_chk++;
      if (active !== ea || abr_sel !== eb || idle !== ei || done !== ed) begin
         n_bad++;
         $display("FAIL %s edge %0d: active=%h abr=%b idle=%b done=%b expected %h %b %b %b",
                  tag, n, active, abr_sel, idle, done, ea, eb, ei, ed);
      end
   endtask

   // one decision, compared on every cycle; poke = extra start and last_idx change mid-run
   task automatic run(input string tag, input logic [31:0] emp, input logic [31:0] zer,
                      input logic abr, input int last, input bit poke);
      logic [31:0] ea; logic eb, ei; int lat;
      predict(emp, zer, abr, last, ea, eb, ei, lat);
      q_empty = emp; q_zero = zer; abr_avail = abr; last_idx = 5'(last); start = 1;
      @(negedge clk);
      start = 0;
      if (poke) last_idx = 5'(last + 7);          // R10: must not matter
      for (int n = 1; n <= lat + 2; n++) begin
         @(negedge clk);
         if (poke && n == 3 && lat >= 4) begin start = 1; last_idx = 5'(last + 13); end  // R9
         else start = 0;
         if (n < lat)       check({tag, " R8 pending"}, n, '0, 0, 0, 0);
         else if (n == lat) check({tag, " R8 done"}, n, ea, eb, ei, 1);
         else               check({tag, " R11 hold"}, n, ea, eb, ei, 0);
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      n_bad++; n_chk++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      rst_n = 0; start = 0; last_idx = '0; q_empty = '1; q_zero = '0; abr_avail = 0;
      repeat (3) @(negedge clk);
      check("R1 reset", 0, '0, 0, 0, 0);
      rst_n = 1;
      @(negedge clk);
      check("R1 after reset", 0, '0, 0, 0, 0);

      run("R2 next queue",  ~32'h0000_0002, '0, 0, 0, 0);
      run("R2 R7 two ready", ~(32'h0010_0004), '0, 1, 5, 0);
      run("R2 wrap",        ~32'h0000_0008, '0, 0, 30, 0);
      run("R2 credit skip", ~32'h0000_0F00, 32'h0000_0300, 0, 6, 0);
      run("R3 sender last", ~32'h0000_0200, '0, 1, 9, 0);
      run("R4 best effort", ~32'h00F0_0000, '1, 1, 3, 0);
      run("R5 any credit",  ~32'h0000_1000, ~32'h0200_0000, 0, 0, 0);
      run("R5 sender last", ~32'h0002_0000, '1, 0, 17, 0);
      run("R6 all empty",   '1, '0, 0, 12, 0);
      run("R9 R10 poke",    ~32'h0010_0004, '0, 1, 5, 1);
      run("R9 R10 poke lap2", ~32'h0000_4000, '1, 0, 20, 1);

      for (int i = 0; i < 40; i++) begin
         logic [31:0] e, z;
         e = $urandom | $urandom | $urandom;      // mostly empty
         z = $urandom | $urandom;
         if (i % 5 == 0) e = '1;
         run("R2 R4 R5 R6 random", e, z, 1'($urandom), int'($urandom % 32), 1'(i % 3 == 0));
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule